// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block handles the memory side of exception entry and exception return for a processor core with a stacked, format-tagged exception frame. When a request to take an exception arrives, the block works out the new status word. It then writes the frame downward through one memory port, one write per beat, and reads the handler address from the vector table. Software traps, faults and hardware interrupts each take this path.

A return request runs the frame the other way. The block reads the frame, steps the stack pointer past any extra longs that the frame's format code implies, and hands back the restored PC, SP and status word. It also builds the two-frame sequence that moves an interrupt from the master stack to the interrupt stack, and it unwinds that sequence on return.

The core passes in its current PC, SP, status word, the other supervisor stack pointer and the vector base. It takes the results when `done` pulses. Status word bits used: T = bit 15, S = bit 13, M = bit 12, interrupt mask = bits 10:8.

Top module: `exc_frame_seq`

## Requirements
- R1: On entry the vector offset is the exception number times four, and `pc_out` becomes the long word read at `vbr` plus that offset.
- R2: The status word after entry is `sr_in` with S set and T cleared. For a hardware request the mask field 10:8 is replaced by `irq_level`; otherwise the mask is kept.
- R3: Before pushing, bit 0 of the stack pointer is cleared. Pushes go downward in this order: extra longs, format word, return PC long, old status word. The old status word ends at the final `sp_out`, the PC at `sp_out`+2 and the format word at `sp_out`+6.
- R4: The format word carries the format code in bits 15:12 and the vector offset in bits 9:0, with bits 11:10 zero.
- R5: Software exception 2 (access fault) uses format 4: the current PC at `sp_out`+12 and `fault_addr` at `sp_out`+8. Exception 3 uses format 2 with `fault_addr` at `sp_out`+8. Exceptions 4, 5, 6, 7 and 9 use format 2 with the current PC at `sp_out`+8. All other exceptions, and every hardware request, use format 0.
- R6: For software exceptions 32 to 47, the pushed return PC is `cur_pc`+2. For all other exceptions it is `cur_pc`.
- R7: A hardware request taken while M is set in `sr_in` writes two frames. The first is a format-0 frame on `sp_in`, whose final value is returned on `alt_sp_out`. The second is a format-1 frame on `alt_sp_in`, holding the new status word with M still set; its final value is returned on `sp_out`. The final `sr_out` has M cleared.
- R8: On return the block reads the status word at SP, the PC at SP+2 and the format word at SP+6. The final SP is SP+8 plus 0, 4, 8 or 52 bytes for formats 0, 2/3, 4 and 7.
- R9: A format-1 frame on return restores its status word and then runs the whole return again. If M is set in that word, the block continues on `alt_sp_in` and returns the popped interrupt stack on `alt_sp_out`. If M is clear, it continues on the same stack.
- R10: A software request for exception 2 that arrives while an access-fault frame is still being built sets `halted` and keeps `busy` high until reset.
- R11: A format code other than 0, 1, 2, 3, 4 or 7 on return is unwound like format 0 and sets the sticky `fmt_err`, which only reset clears.
- R12: Each memory access holds `mem_valid`, `mem_addr` and the size flag `mem_long` (1 = 32-bit, 0 = 16-bit in bits 15:0) until `mem_ready`. `done` pulses for one cycle when the results are committed.
- R13: An entry request beats a return request given in the same cycle. Requests made while busy, other than the case in R10, are ignored.
- R14: After reset, `busy`, `done`, `halted`, `fmt_err`, `mem_valid` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_exc | input | 1 | Request to take an exception |
| exc_num | input | 8 | Exception number |
| exc_hw | input | 1 | Request is a hardware interrupt |
| irq_level | input | 3 | Pending interrupt level |
| fault_addr | input | 32 | Faulting address for formats 2 and 4 |
| cur_pc | input | 32 | PC of the current instruction |
| start_rte | input | 1 | Request to return from an exception |
| sr_in | input | 16 | Current status word |
| sp_in | input | 32 | Active stack pointer |
| alt_sp_in | input | 32 | Other supervisor stack pointer |
| vbr | input | 32 | Vector table base |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit, 0 = 16-bit |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data (16-bit in 15:0) |
| mem_ready | input | 1 | Access accepted / read data valid |
| mem_rdata | input | 32 | Read data (16-bit in 15:0) |
| busy | output | 1 | Sequence in progress or halted |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Double fault seen |
| fmt_err | output | 1 | Sticky unknown-format flag |
| pc_out | output | 32 | Resulting PC |
| sp_out | output | 32 | Resulting active SP |
| alt_sp_out | output | 32 | Resulting other stack pointer |
| sr_out | output | 16 | Resulting status word |

## Verification
Two events can meet in one cycle at the request inputs. One is an entry and a return requested together; the bench raises both in the same cycle and expects a plain entry frame with no return. The other is a second access-fault request during the build of an access-fault frame. The bench issues it two cycles into the push and judges the result by `halted`, by `busy` staying high and by the absence of any `done`. A return request made in the middle of an entry must leave the entry frame and results unchanged.

// File: rtl/exc_frame_seq.sv
module exc_frame_seq #(
  parameter int XW = 32,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_exc,
  input  logic [NW-1:0] exc_num,
  input  logic          exc_hw,
  input  logic [2:0]    irq_level,
  input  logic [XW-1:0] fault_addr,
  input  logic [XW-1:0] cur_pc,
  input  logic          start_rte,
  input  logic [15:0]   sr_in,
  input  logic [XW-1:0] sp_in,
  input  logic [XW-1:0] alt_sp_in,
  input  logic [XW-1:0] vbr,
  output logic          mem_valid,
  output logic          mem_write,
  output logic          mem_long,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [XW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          halted,
  output logic          fmt_err,
  output logic [XW-1:0] pc_out,
  output logic [XW-1:0] sp_out,
  output logic [XW-1:0] alt_sp_out,
  output logic [15:0]   sr_out
);
  localparam int OW = NW + 2;
  localparam int B_T = 15, B_S = 13, B_M = 12;

  typedef enum logic [3:0] {
    IDLE, E_X1, E_X2, E_FV, E_PC, E_SR, E_VEC, R_SR, R_PC, R_FV, HALT
  } st_t;

  st_t st;
  logic [XW-1:0] sp_r, alt_r, pc_r, vbr_r, pc_cur, retpc, addr_f;
  logic [15:0] sr_r, old_sr;
  logic [3:0] fmt;
  logic [OW-1:0] voff;
  logic thr, is_af, xfer, in_entry, known;
  logic [5:0] skip;
  logic [15:0] nsr;

  function automatic logic [3:0] classify(input logic [NW-1:0] n, input logic hw);
    if (hw) return 4'd0;
    case (n)
      8'd2: return 4'd4;
      8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd9: return 4'd2;
      default: return 4'd0;
    endcase
  endfunction

  assign in_entry = (st == E_X1) || (st == E_X2) || (st == E_FV) ||
                    (st == E_PC) || (st == E_SR) || (st == E_VEC);
  assign mem_valid = in_entry || (st == R_SR) || (st == R_PC) || (st == R_FV);
  assign mem_write = in_entry && (st != E_VEC);
  assign mem_long  = (st == E_X1) || (st == E_X2) || (st == E_PC) ||
                     (st == E_VEC) || (st == R_PC);
  assign xfer = mem_valid && mem_ready;
  assign busy = (st != IDLE);

  always_comb begin
    case (st)
      E_X1, E_X2, E_PC: mem_addr = sp_r - XW'(4);
      E_FV, E_SR:       mem_addr = sp_r - XW'(2);
      E_VEC:            mem_addr = vbr_r + XW'(voff);
      default:          mem_addr = sp_r;
    endcase
    case (st)
      E_X1:    mem_wdata = (fmt == 4'd4) ? pc_cur : addr_f;
      E_X2:    mem_wdata = addr_f;
      E_FV:    mem_wdata = XW'({fmt, 2'b00, voff[9:0]});
      E_PC:    mem_wdata = retpc;
      E_SR:    mem_wdata = XW'(old_sr);
      default: mem_wdata = '0;
    endcase
  end

  always_comb begin
    known = 1'b1;
    case (mem_rdata[15:12])
      4'd0, 4'd1: skip = 6'd0;
      4'd2, 4'd3: skip = 6'd4;
      4'd4:       skip = 6'd8;
      4'd7:       skip = 6'd52;
      default: begin skip = 6'd0; known = 1'b0; end
    endcase
  end

  always_comb begin
    nsr = sr_in;
    nsr[B_S] = 1'b1;
    nsr[B_T] = 1'b0;
    if (exc_hw) nsr[10:8] = irq_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; sp_r <= '0; alt_r <= '0; pc_r <= '0; vbr_r <= '0;
      pc_cur <= '0; retpc <= '0; addr_f <= '0; sr_r <= '0; old_sr <= '0;
      fmt <= '0; voff <= '0; thr <= 1'b0; is_af <= 1'b0;
      done <= 1'b0; halted <= 1'b0; fmt_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          if (start_exc) begin
            voff   <= {exc_num, 2'b00};
            old_sr <= sr_in;
            sr_r   <= nsr;
            sp_r   <= {sp_in[XW-1:1], 1'b0};
            alt_r  <= alt_sp_in;
            vbr_r  <= vbr;
            pc_cur <= cur_pc;
            retpc  <= (!exc_hw && exc_num >= 8'd32 && exc_num <= 8'd47) ? cur_pc + XW'(2) : cur_pc;
            addr_f <= (!exc_hw && (exc_num == 8'd2 || exc_num == 8'd3)) ? fault_addr : cur_pc;
            thr    <= exc_hw && sr_in[B_M];
            is_af  <= !exc_hw && exc_num == 8'd2;
            fmt    <= classify(exc_num, exc_hw);
            st     <= (classify(exc_num, exc_hw) != 4'd0) ? E_X1 : E_FV;
          end else if (start_rte) begin
            sp_r  <= sp_in;
            alt_r <= alt_sp_in;
            st    <= R_SR;
          end
        end
        HALT: st <= HALT;
        default: begin
          if (in_entry && is_af && start_exc && !exc_hw && exc_num == 8'd2) begin
            st <= HALT;
            halted <= 1'b1;
          end else if (xfer) begin
            case (st)
              E_X1: begin sp_r <= mem_addr; st <= (fmt == 4'd4) ? E_X2 : E_FV; end
              E_X2: begin sp_r <= mem_addr; st <= E_FV; end
              E_FV: begin sp_r <= mem_addr; st <= E_PC; end
              E_PC: begin sp_r <= mem_addr; st <= E_SR; end
              E_SR: begin
                if (thr) begin
                  thr      <= 1'b0;
                  alt_r    <= mem_addr;
                  sp_r     <= {alt_r[XW-1:1], 1'b0};
                  old_sr   <= sr_r;
                  sr_r[B_M] <= 1'b0;
                  fmt      <= 4'd1;
                  st       <= E_FV;
                end else begin
                  sp_r <= mem_addr;
                  st   <= E_VEC;
                end
              end
              E_VEC: begin pc_r <= mem_rdata; is_af <= 1'b0; done <= 1'b1; st <= IDLE; end
              R_SR: begin sr_r <= mem_rdata[15:0]; sp_r <= sp_r + XW'(2); st <= R_PC; end
              R_PC: begin pc_r <= mem_rdata; sp_r <= sp_r + XW'(4); st <= R_FV; end
              R_FV: begin
                if (mem_rdata[15:12] == 4'd1) begin
                  if (sr_r[B_M]) begin
                    alt_r <= sp_r + XW'(2);
                    sp_r  <= alt_r;
                  end else begin
                    sp_r <= sp_r + XW'(2);
                  end
                  st <= R_SR;
                end else begin
                  sp_r <= sp_r + XW'(2) + XW'(skip);
                  if (!known) fmt_err <= 1'b1;
                  done <= 1'b1;
                  st <= IDLE;
                end
              end
              default: st <= st;
            endcase
          end
        end
      endcase
    end
  end

  assign pc_out = pc_r;
  assign sp_out = sp_r;
  assign alt_sp_out = alt_r;
  assign sr_out = sr_r;

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !halted && !start_exc |=> mem_valid && $stable(mem_addr) && $stable(mem_long));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_push_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> !mem_addr[0]);
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && busy && !mem_valid);
  p_super_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == E_VEC |-> sr_r[B_S] && !sr_r[B_T]);
  p_quiet_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !halted);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);
endmodule

// File: tb/exc_frame_seq_tb_top.sv
module exc_frame_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_exc = 0, exc_hw = 0, start_rte = 0;
  logic [7:0] exc_num = 0;
  logic [2:0] irq_level = 0;
  logic [31:0] fault_addr = 0, cur_pc = 0, sp_in = 0, alt_sp_in = 0, vbr = 0;
  logic [15:0] sr_in = 0;
  logic mem_valid, mem_write, mem_long, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic busy, done, halted, fmt_err;
  logic [31:0] pc_out, sp_out, alt_sp_out;
  logic [15:0] sr_out;
  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] mem [0:4095];

  always #2 clk = ~clk;

  exc_frame_seq dut_i (.*);

  function automatic logic [15:0] rd16(input logic [31:0] a);
    logic [11:0] x = a[11:0];
    return {mem[x], mem[x + 12'd1]};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rd16(a), rd16(a + 2)};
  endfunction
  task automatic wr16(input logic [31:0] a, input logic [15:0] d);
    mem[a[11:0]] = d[15:8]; mem[a[11:0] + 12'd1] = d[7:0];
  endtask
  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    wr16(a, d[31:16]); wr16(a + 2, d[15:0]);
  endtask

  assign mem_rdata = mem_long ? rd32(mem_addr) : {16'h0, rd16(mem_addr)};
  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_write) begin
      if (mem_long) wr32(mem_addr, mem_wdata); else wr16(mem_addr, mem_wdata[15:0]);
    end
    mem_ready <= mem_valid && !mem_ready;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    check({req, " done"}, 32'(done), 32'd1);
  endtask

  task automatic go_exc(input logic [7:0] n, input logic hw, input logic [2:0] lvl,
                        input logic [31:0] fa, input logic [31:0] pc, input logic [15:0] sr,
                        input logic [31:0] sp, input logic [31:0] alt, input logic also_rte);
    @(negedge clk);
    exc_num = n; exc_hw = hw; irq_level = lvl; fault_addr = fa; cur_pc = pc;
    sr_in = sr; sp_in = sp; alt_sp_in = alt; vbr = 32'h100;
    start_exc = 1'b1; start_rte = also_rte;
    @(negedge clk);
    start_exc = 1'b0; start_rte = 1'b0;
  endtask

  task automatic entry_case(input string req, input logic [7:0] n, input logic hw,
                            input logic [2:0] lvl, input logic [15:0] sr, input logic [31:0] sp,
                            input logic [3:0] efmt, input logic [31:0] eaddr,
                            input logic [31:0] eret, input logic also_rte);
    logic [31:0] fin;
    logic [15:0] esr;
    fin = {sp[31:1], 1'b0} - 32'd8 - ((efmt == 4'd2) ? 32'd4 : (efmt == 4'd4) ? 32'd8 : 32'd0);
    esr = (sr | 16'h2000) & 16'h7FFF;
    if (hw) esr[10:8] = lvl;
    go_exc(n, hw, lvl, 32'h0000_0ABC, 32'h0000_1000, sr, sp, 32'h0E00, also_rte);
    wait_done(req);
    check({req, " R3 sp"}, sp_out, fin);
    check({req, " R2 sr"}, 32'(sr_out), 32'(esr));
    check({req, " R3 old sr at sp"}, 32'(rd16(fin)), 32'(sr));
    check({req, " R6 ret pc"}, rd32(fin + 2), eret);
    check({req, " R4 fmt word"}, 32'(rd16(fin + 6)), 32'({efmt, 2'b00, n, 2'b00}));
    if (efmt == 4'd2) check({req, " R5 addr"}, rd32(fin + 8), eaddr);
    if (efmt == 4'd4) begin
      check({req, " R5 addr"}, rd32(fin + 8), 32'h0000_0ABC);
      check({req, " R5 pc"}, rd32(fin + 12), 32'h0000_1000);
    end
    check({req, " R1 handler"}, pc_out, 32'h4000_0000 + 32'(n));
  endtask

  task automatic rte_case(input string req, input logic [3:0] f, input logic [31:0] skip,
                          input logic exp_err);
    logic [31:0] sp = 32'h0A00;
    wr16(sp, 16'h0011); wr32(sp + 2, 32'h0000_2222); wr16(sp + 6, {f, 12'h018});
    @(negedge clk);
    sp_in = sp; alt_sp_in = 32'h0E00; start_rte = 1'b1;
    @(negedge clk);
    start_rte = 1'b0;
    wait_done(req);
    check({req, " R8 sp"}, sp_out, sp + 32'd8 + skip);
    check({req, " R8 pc"}, pc_out, 32'h0000_2222);
    check({req, " R8 sr"}, 32'(sr_out), 32'h0011);
    check({req, " R11 fmt_err"}, 32'(fmt_err), 32'(exp_err));
  endtask

  task automatic t_reset();
    check("R14 busy", 32'(busy), 0);
    check("R14 done", 32'(done), 0);
    check("R14 halted", 32'(halted), 0);
    check("R14 fmt_err", 32'(fmt_err), 0);
    check("R14 mem_valid", 32'(mem_valid), 0);
    check("R14 sp_out", sp_out, 0);
    check("R14 pc_out", pc_out, 0);
  endtask

  task automatic t_throwaway();
    go_exc(8'd29, 1'b1, 3'd5, 0, 32'h0000_3000, 16'h3100, 32'h0900, 32'h0E01, 1'b0);
    wait_done("R7");
    check("R7 master final", alt_sp_out, 32'h08F8);
    check("R7 master sr", 32'(rd16(32'h08F8)), 32'h3100);
    check("R7 master fmt", 32'(rd16(32'h08FE)), 32'h0074);
    check("R7 isp final", sp_out, 32'h0DF8);
    check("R7 isp sr", 32'(rd16(32'h0DF8)), 32'h3500);
    check("R7 isp pc", rd32(32'h0DFA), 32'h0000_3000);
    check("R7 isp fmt", 32'(rd16(32'h0DFE)), 32'h1074);
    check("R7 final sr", 32'(sr_out), 32'h2500);
    check("R7 R1 handler", pc_out, 32'h4000_001D);
  endtask

  task automatic t_rte_chain(input logic mset);
    wr16(32'h0A40, mset ? 16'h3000 : 16'h2000); wr32(32'h0A42, 32'h0); wr16(32'h0A46, 16'h1074);
    if (mset) begin
      wr16(32'h0B00, 16'h0004); wr32(32'h0B02, 32'h0000_1234); wr16(32'h0B06, 16'h0074);
    end else begin
      wr16(32'h0A48, 16'h0004); wr32(32'h0A4A, 32'h0000_1234); wr16(32'h0A4E, 16'h0074);
    end
    @(negedge clk);
    sp_in = 32'h0A40; alt_sp_in = 32'h0B00; start_rte = 1'b1;
    @(negedge clk);
    start_rte = 1'b0;
    wait_done("R9");
    check("R9 sp", sp_out, mset ? 32'h0B08 : 32'h0A50);
    check("R9 alt", alt_sp_out, mset ? 32'h0A48 : 32'h0B00);
    check("R9 pc", pc_out, 32'h0000_1234);
    check("R9 sr", 32'(sr_out), 32'h0004);
  endtask

  task automatic t_double_fault();
    go_exc(8'd2, 1'b0, 3'd0, 32'h0ABC, 32'h1000, 16'h2000, 32'h0900, 32'h0E00, 1'b0);
    repeat (2) @(negedge clk);
    exc_num = 8'd2; start_exc = 1'b1;
    @(negedge clk);
    start_exc = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (done) check("R10 no done", 32'(done), 0);
    end
    check("R10 halted", 32'(halted), 1);
    check("R10 busy", 32'(busy), 1);
    check("R10 mem idle", 32'(mem_valid), 0);
    do_reset();
    check("R10 R14 halt cleared", 32'(halted), 0);
  endtask

  task automatic t_busy_ignore();
    go_exc(8'd64, 1'b0, 3'd0, 0, 32'h0000_1000, 16'h0000, 32'h0900, 32'h0E00, 1'b0);
    repeat (3) @(negedge clk);
    sp_in = 32'h0A00; start_rte = 1'b1;
    @(negedge clk);
    start_rte = 1'b0;
    wait_done("R13 busy");
    check("R13 busy sp", sp_out, 32'h08F8);
    check("R13 busy pc", pc_out, 32'h4000_0040);
    repeat (20) @(negedge clk);
    check("R13 stays idle", 32'(busy), 0);
    check("R13 sp unchanged", sp_out, 32'h08F8);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int n = 0; n < 256; n++) wr32(32'h100 + 32'(n) * 4, 32'h4000_0000 + 32'(n));
    do_reset();
    t_reset();
    entry_case("R5 fmt0 user", 8'd64, 1'b0, 3'd0, 16'h8015, 32'h0900, 4'd0, 0, 32'h1000, 1'b0);
    entry_case("R5 fmt2 div0", 8'd5, 1'b0, 3'd0, 16'h2700, 32'h0901, 4'd2, 32'h1000, 32'h1000, 1'b0);
    entry_case("R5 fmt2 addr", 8'd3, 1'b0, 3'd0, 16'h0000, 32'h0900, 4'd2, 32'h0ABC, 32'h1000, 1'b0);
    entry_case("R5 fmt4 af", 8'd2, 1'b0, 3'd0, 16'h2300, 32'h0900, 4'd4, 0, 32'h1000, 1'b0);
    entry_case("R6 trap", 8'd33, 1'b0, 3'd0, 16'h0000, 32'h0900, 4'd0, 0, 32'h1002, 1'b0);
    entry_case("R6 trap15", 8'd47, 1'b0, 3'd0, 16'h0000, 32'h0900, 4'd0, 0, 32'h1002, 1'b0);
    entry_case("R2 hw irq", 8'd26, 1'b1, 3'd2, 16'h2700, 32'h0900, 4'd0, 0, 32'h1000, 1'b0);
    entry_case("R13 both", 8'd64, 1'b0, 3'd0, 16'h0000, 32'h0900, 4'd0, 0, 32'h1000, 1'b1);
    t_throwaway();
    rte_case("R8 f0", 4'd0, 0, 1'b0);
    rte_case("R8 f2", 4'd2, 4, 1'b0);
    rte_case("R8 f3", 4'd3, 4, 1'b0);
    rte_case("R8 f4", 4'd4, 8, 1'b0);
    rte_case("R8 f7", 4'd7, 52, 1'b0);
    t_rte_chain(1'b1);
    t_rte_chain(1'b0);
    rte_case("R11 bad", 4'd10, 0, 1'b1);
    rte_case("R11 sticky", 4'd0, 0, 1'b1);
    t_busy_ignore();
    t_double_fault();
    finish_run();
  end
endmodule